// File: doc/BRIEF.md
# Phase-Shifted Dual-Bridge PWM Generator

This block drives the gates of two full bridges that share one switching frequency. Each bridge has its own carrier counter. The secondary counter is re-seeded from a phase input every time the primary counter wraps. As a result, the secondary waveform trails the primary by a programmable number of clock cycles, and that offset sets the direction and amount of power that moves between the bridges.

Each bridge has two legs. Each leg has a complementary high-side and low-side command, and a fixed dead time separates the two commands of a leg. Each bridge has its own duty value. Leg A conducts at the start of the carrier and leg B conducts from mid-period, each for the duty count. A duty of half the period gives the usual 50% complementary square wave.

The period, both duties and the phase are taken from the inputs only at carrier wrap points, so software may change them at any time. A per-bridge enable forces every output of that bridge low at once.

Top module: `dab_pwm_gen`

## Requirements
- R1: While reset is asserted all eight gate outputs are low. After reset the carrier period is 16 cycles and both duties are 0 until the first primary wrap.
- R2: The primary counter runs 0..P-1, where P is the active period. Leg A of a bridge is on in the cycle after each counter value below the effective duty d (hi output, subject to R5).
- R3: Leg B is on in the cycle after each counter value in [P/2, P/2+d). It is always cleared after counter value 0. With d = P/2, legs A and B form a complementary square wave.
- R4: The effective duty is min(duty, P/2). A duty of 0 keeps both legs off.
- R5: In each leg, hi = 1 only when the leg state is 1 and that state was also 1 in the previous DEAD cycles. lo is the same for state 0. hi and lo are never high together.
- R6: When the primary wraps, the secondary counter loads (P - phase) mod P. The secondary waveform therefore lags the primary by `phase` cycles (0 <= phase < P).
- R7: period, pri_duty and phase are taken only when the primary counter wraps. sec_duty is taken only when the secondary counter wraps. Changes at other times have no effect until then.
- R8: With an enable low, all four outputs of that bridge are low in the same cycle, and the leg state and dead-time history are cleared. The other bridge is not affected.
- R9: The secondary duty is independent of the primary duty. It sets the secondary legs through the same A/B windows and clamp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period | input | CW | Requested carrier period in cycles (even, >= 4) |
| pri_duty | input | CW | Requested primary duty count |
| sec_duty | input | CW | Requested secondary duty count |
| phase | input | CW | Secondary lag in cycles, below period |
| pri_en | input | 1 | Primary bridge enable |
| sec_en | input | 1 | Secondary bridge enable |
| pri_hi | output | 2 | Primary high-side commands, bit 0 leg A, bit 1 leg B |
| pri_lo | output | 2 | Primary low-side commands, bit 0 leg A, bit 1 leg B |
| sec_hi | output | 2 | Secondary high-side commands, bit 0 leg A, bit 1 leg B |
| sec_lo | output | 2 | Secondary low-side commands, bit 0 leg A, bit 1 leg B |

## Verification
A corrupted counter or a shadow register loaded early shows up at the gate pins within one carrier period, as an edge that moves or a pulse of the wrong width. A wrong secondary seed shifts every secondary edge from the first cycle after the wrap.

A stuck leg state or a bad dead-time count appears within DEAD+1 cycles, as hi and lo that either overlap or stay both low for too long. Right after an enable or a phase jump, legs that are driven by events may not match the window view until the next full carrier. Those outputs are therefore compared only once that carrier has completed.

// File: rtl/dab_pwm_pkg.sv
`timescale 1ns/1ps
package dab_pwm_pkg;
  localparam int NUM_BRIDGES = 2;
  localparam int NUM_LEGS    = 2;

  // duty clamp: a leg window may not exceed half the carrier
  function automatic int unsigned eff_duty(int unsigned duty, int unsigned prd);
    int unsigned half;
    half = prd >> 1;
    return (duty > half) ? half : duty;
  endfunction

  // value the lagging counter takes at the primary wrap
  function automatic int unsigned lag_seed(int unsigned ph, int unsigned prd);
    return (ph == 0) ? 0 : prd - ph;
  endfunction
endpackage

// File: rtl/dab_timebase.sv
`timescale 1ns/1ps
module dab_timebase #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] prd,
  input  logic          sync_in,
  input  logic [CW-1:0] sync_val,
  input  logic [CW-1:0] duty_in,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] duty_act,
  output logic          wrap
);
  assign wrap = (cnt == prd - CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      duty_act <= '0;
    end else begin
      if (sync_in)   cnt <= sync_val;
      else if (wrap) cnt <= '0;
      else           cnt <= cnt + CW'(1);
      if (wrap) duty_act <= duty_in;
    end
  end

  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < prd);
  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !sync_in) |=> (cnt == '0));
  p_shadow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(duty_act));
endmodule

// File: rtl/dab_bridge_aq.sv
`timescale 1ns/1ps
module dab_bridge_aq
  import dab_pwm_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [CW-1:0]       cnt,
  input  logic [CW-1:0]       prd,
  input  logic [CW-1:0]       duty,
  output logic [NUM_LEGS-1:0] leg_d,
  output logic [NUM_LEGS-1:0] leg_q
);
  logic [CW-1:0] half, dc, cb;
  logic ev_zero, ev_ca, ev_half, ev_cb;
  logic [NUM_LEGS-1:0] nxt;

  assign half    = prd >> 1;
  assign dc      = CW'(eff_duty(32'(duty), 32'(prd)));
  assign cb      = half + dc;
  assign ev_zero = (cnt == '0);
  assign ev_ca   = (cnt == dc);
  assign ev_half = (cnt == half);
  assign ev_cb   = (cnt == cb);

  // action qualifier: clear has priority over set on the same count
  always_comb begin
    nxt = leg_q;
    if (ev_zero)          nxt[0] = 1'b1;
    if (ev_ca)            nxt[0] = 1'b0;
    if (ev_half)          nxt[1] = 1'b1;
    if (ev_cb || ev_zero) nxt[1] = 1'b0;
    leg_d = en ? nxt : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) leg_q <= '0;
    else        leg_q <= leg_d;
  end

  p_lega_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ev_ca) |=> !leg_q[0]);
  p_legb_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ev_zero) |=> !leg_q[1]);
endmodule

// File: rtl/dab_leg_dt.sv
`timescale 1ns/1ps
module dab_leg_dt #(
  parameter int DEAD = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic leg_d,
  input  logic leg_q,
  output logic hi,
  output logic lo
);
  localparam int DW = $clog2(DEAD + 2);
  localparam logic [DW-1:0] DLIM = DW'(DEAD);

  logic [DW-1:0] dcnt;
  logic settled;

  always_ff @(posedge clk) begin
    if (!rst_n)               dcnt <= '0;
    else if (!en)             dcnt <= '0;
    else if (leg_d != leg_q)  dcnt <= '0;
    else if (dcnt != DLIM)    dcnt <= dcnt + DW'(1);
  end

  assign settled = (dcnt == DLIM);
  assign hi = en & leg_q & settled;
  assign lo = en & ~leg_q & settled;

  p_no_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi && lo));
  p_dead_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((DEAD > 0) && $rose(hi)) |-> !$past(lo));
  p_enable_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(!en)) |-> !hi);
endmodule

// File: rtl/dab_pwm_gen.sv
`timescale 1ns/1ps
module dab_pwm_gen
  import dab_pwm_pkg::*;
#(
  parameter int CW         = 8,
  parameter int DEAD       = 2,
  parameter int RST_PERIOD = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] period,
  input  logic [CW-1:0] pri_duty,
  input  logic [CW-1:0] sec_duty,
  input  logic [CW-1:0] phase,
  input  logic          pri_en,
  input  logic          sec_en,
  output logic [1:0]    pri_hi,
  output logic [1:0]    pri_lo,
  output logic [1:0]    sec_hi,
  output logic [1:0]    sec_lo
);
  localparam logic [CW-1:0] PRD_RST = CW'(RST_PERIOD);

  logic [CW-1:0] prd_act;
  logic [CW-1:0] sync_val;
  logic [CW-1:0] cnt_b  [NUM_BRIDGES];
  logic [CW-1:0] duty_b [NUM_BRIDGES];
  logic [CW-1:0] req_b  [NUM_BRIDGES];
  logic          wrap_b [NUM_BRIDGES];
  logic          en_b   [NUM_BRIDGES];
  logic [NUM_LEGS-1:0] leg_d_b [NUM_BRIDGES];
  logic [NUM_LEGS-1:0] leg_q_b [NUM_BRIDGES];
  logic [NUM_LEGS-1:0] hi_b    [NUM_BRIDGES];
  logic [NUM_LEGS-1:0] lo_b    [NUM_BRIDGES];

  assign req_b[0] = pri_duty;
  assign req_b[1] = sec_duty;
  assign en_b[0]  = pri_en;
  assign en_b[1]  = sec_en;
  assign sync_val = CW'(lag_seed(32'(phase), 32'(period)));

  // shared period, taken at the primary wrap
  always_ff @(posedge clk) begin
    if (!rst_n)         prd_act <= PRD_RST;
    else if (wrap_b[0]) prd_act <= period;
  end

  for (genvar b = 0; b < NUM_BRIDGES; b++) begin : g_bridge
    localparam bit IS_SEC = (b != 0);
    logic sync_b;
    assign sync_b = IS_SEC ? wrap_b[0] : 1'b0;

    dab_timebase #(.CW(CW)) u_tb (
      .clk(clk), .rst_n(rst_n), .prd(prd_act), .sync_in(sync_b),
      .sync_val(sync_val), .duty_in(req_b[b]), .cnt(cnt_b[b]),
      .duty_act(duty_b[b]), .wrap(wrap_b[b])
    );

    dab_bridge_aq #(.CW(CW)) u_aq (
      .clk(clk), .rst_n(rst_n), .en(en_b[b]), .cnt(cnt_b[b]),
      .prd(prd_act), .duty(duty_b[b]), .leg_d(leg_d_b[b]), .leg_q(leg_q_b[b])
    );

    for (genvar l = 0; l < NUM_LEGS; l++) begin : g_leg
      dab_leg_dt #(.DEAD(DEAD)) u_dt (
        .clk(clk), .rst_n(rst_n), .en(en_b[b]),
        .leg_d(leg_d_b[b][l]), .leg_q(leg_q_b[b][l]),
        .hi(hi_b[b][l]), .lo(lo_b[b][l])
      );
    end
  end

  assign pri_hi = hi_b[0];
  assign pri_lo = lo_b[0];
  assign sec_hi = hi_b[1];
  assign sec_lo = lo_b[1];

  p_prd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_b[0] |=> $stable(prd_act));
  p_phase_lag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wrap_b[0]) && ($past(phase) < prd_act)) |->
      ((({1'b0, cnt_b[1]} + {1'b0, $past(phase)}) % {1'b0, prd_act}) == '0));
endmodule

// File: tb/tb_dab_pwm_gen.sv
`timescale 1ns/1ps
module tb_dab_pwm_gen;
  localparam int DT   = 2;
  localparam int RSTN = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] d_period = 8, d_pri_duty = 4, d_sec_duty = 4, d_phase = 0;
  logic d_pri_en = 1'b1, d_sec_en = 1'b1;
  logic [1:0] pri_hi, pri_lo, sec_hi, sec_lo;

  always #2.5 clk = ~clk;

  dab_pwm_gen dut (
    .clk(clk), .rst_n(rst_n), .period(d_period), .pri_duty(d_pri_duty),
    .sec_duty(d_sec_duty), .phase(d_phase), .pri_en(d_pri_en), .sec_en(d_sec_en),
    .pri_hi(pri_hi), .pri_lo(pri_lo), .sec_hi(sec_hi), .sec_lo(sec_lo)
  );

  typedef struct { logic [7:0] exp; logic [7:0] msk; string req; } item_t;
  item_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;
  string cur_req = "R1";

  // pending input values, applied after the next edge
  logic [7:0] n_period = 8, n_pri_duty = 4, n_sec_duty = 4, n_phase = 0;
  logic n_pri_en = 1'b1, n_sec_en = 1'b1;

  // reference state
  int nact, bp, bs, dp, ds, ph_last, mask_p, mask_s;
  bit legv[4];
  int run_len[4];
  bit pen_prev, sen_prev;

  function automatic bit win_a(int pos, int d, int n);
    int dc = (d > n / 2) ? n / 2 : d;
    return pos < dc;
  endfunction

  function automatic bit win_b(int pos, int d, int n);
    int dc = (d > n / 2) ? n / 2 : d;
    return (pos >= n / 2) && (pos < n / 2 + dc);
  endfunction

  task automatic model_edge();
    bit nl[4];
    bit pw, sw;
    if (mask_p > 0) mask_p--;
    if (mask_s > 0) mask_s--;
    nl[0] = win_a(bp, dp, nact); nl[1] = win_b(bp, dp, nact);
    nl[2] = win_a(bs, ds, nact); nl[3] = win_b(bs, ds, nact);
    for (int k = 0; k < 4; k++) begin
      bit e = (k < 2) ? d_pri_en : d_sec_en;
      if (!e) begin
        legv[k] = 0; run_len[k] = 0;
      end else begin
        if (nl[k] != legv[k]) run_len[k] = 0;
        else if (run_len[k] < DT) run_len[k]++;
        legv[k] = nl[k];
      end
    end
    if (d_pri_en && !pen_prev) mask_p = 2 * nact + DT + 3;
    if (d_sec_en && !sen_prev) mask_s = 2 * nact + DT + 3;
    pen_prev = d_pri_en; sen_prev = d_sec_en;
    pw = (bp == nact - 1);
    sw = (bs == nact - 1);
    if (sw) ds = int'(d_sec_duty);
    if (pw) begin
      if (int'(d_phase) != ph_last || int'(d_period) != nact)
        mask_s = 2 * int'(d_period) + DT + 3;
      nact = int'(d_period); dp = int'(d_pri_duty); ph_last = int'(d_phase);
      bp = 0;
      bs = (nact - ph_last) % nact;
    end else begin
      bp++;
      bs = sw ? 0 : bs + 1;
    end
  endtask

  task automatic push_expected();
    item_t it;
    it.exp = '0;
    for (int k = 0; k < 4; k++) begin
      bit e = (k < 2) ? d_pri_en : d_sec_en;
      int hb = (k < 2) ? k : k + 2;
      it.exp[hb]     = e && legv[k] && (run_len[k] == DT);
      it.exp[hb + 2] = e && !legv[k] && (run_len[k] == DT);
    end
    it.msk = {(mask_s == 0) ? 4'hF : 4'h0, (mask_p == 0) ? 4'hF : 4'h0};
    it.req = cur_req;
    q.push_back(it);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      model_edge();
      if (i == 0) begin
        d_period = n_period; d_pri_duty = n_pri_duty; d_sec_duty = n_sec_duty;
        d_phase = n_phase; d_pri_en = n_pri_en; d_sec_en = n_sec_en;
      end
      push_expected();
    end
  endtask

  // monitor: compares design outputs with queued expectations
  always @(negedge clk) begin
    if (rst_n && q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = q.pop_front();
      act = {sec_lo, sec_hi, pri_lo, pri_hi};
      if (it.msk != 0) begin
        checks++;
        if (((act ^ it.exp) & it.msk) != 0) begin
          errors++;
          $display("FAIL %s t=%0t actual=%b expected=%b mask=%b", it.req, $time, act, it.exp, it.msk);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: outputs low while reset is held, even with enables high
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      checks++;
      if ({sec_lo, sec_hi, pri_lo, pri_hi} != 8'h00) begin
        errors++;
        $display("FAIL R1 reset actual=%b expected=00000000", {sec_lo, sec_hi, pri_lo, pri_hi});
      end
    end
    @(posedge clk); #1;
    rst_n = 1'b1;
    nact = RSTN; bp = 0; bs = 0; dp = 0; ds = 0; ph_last = 0; mask_p = 0; mask_s = 0;
    for (int k = 0; k < 4; k++) begin legv[k] = 0; run_len[k] = 0; end
    pen_prev = 1; sen_prev = 1;

    cur_req = "R1";  run(16);              // reset period and zero duty
    cur_req = "R2 R3"; run(40);            // period 8, 50% complementary
    cur_req = "R6";  n_phase = 2; run(60); // secondary lags by 2
    cur_req = "R7";  n_period = 12; n_pri_duty = 2; run(50);
    cur_req = "R4 R9"; n_sec_duty = 9; n_pri_duty = 0; n_phase = 5; run(60);
    cur_req = "R5";  n_pri_duty = 1; n_sec_duty = 3; run(40);
    cur_req = "R8";  n_pri_en = 0; run(30);
    n_pri_en = 1; run(50);
    n_sec_en = 0; run(30);
    n_sec_en = 1; run(60);
    cur_req = "R2 R3"; n_period = 8; n_pri_duty = 4; n_sec_duty = 4; n_phase = 0; run(50);
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule